// File: doc/BRIEF.md
# E1 Spare-Bit Serial Link Port

This block gives a serial side channel into the national spare bits (Sa4 to Sa8) and the international bit (Si) of a 2.048 Mbit/s E1 stream. The receive half copies every incoming bit to a link data output. It also drives a link clock that is gated so it only pulses inside the spare-bit slots the host enables, so an external shift register can capture exactly those bits. A frame-boundary strobe marks the Si slot.

The transmit half rebuilds the outgoing stream. It copies the serial input everywhere except the five spare-bit slots. A per-bit source mask fills each of those slots either from an external link input or from a host value. The host value is latched once per frame. Setting every mask bit and wiring the link input to the serial input passes the spare bits through untouched.

Each half has its own position counter. A sync input restarts that counter, because finding frame alignment is left to a neighbouring block. Every bit lasts `BIT_PHASES` clock cycles. This is what lets the link clock be centred inside a bit.

Top module: `e1_sa_link`

## Requirements
- R1: `rx_link` equals the value `rx_ser` had one clock earlier, in every bit of every frame.
- R2: `rx_fsync` is high for every clock of frame bit index 0 (the Si slot), one clock late, in both frame parities, and low at every other bit index.
- R3: `rx_lclk` may go high only in odd frames, and only at frame bit indices 3..7 (Sa4..Sa8) whose bit in `rx_sa_mask` is 1, where mask bit 0 maps to Sa4 and mask bit 4 maps to Sa8.
- R4: Inside an enabled spare-bit slot, `rx_lclk` is high exactly for phases BIT_PHASES/4 up to BIT_PHASES/4+BIT_PHASES/2-1, one clock late, and low in phase 0 and in the last phase.
- R5: `tx_out` equals `tx_ser` one clock later at every position except Sa4..Sa8 of odd frames.
- R6: At Sa slot k of an odd frame with `tx_sa_mask[k]`=1, `tx_out` carries the `tx_link` value of one clock earlier.
- R7: At Sa slot k of an odd frame with `tx_sa_mask[k]`=0, `tx_out` carries bit k of the `tx_sa_reg` value captured at phase 0 of bit 0 of the same frame.
- R8: A change of `tx_sa_reg` after the frame start has no effect on `tx_out` until the next frame start.
- R9: With `tx_sa_mask`=5'b11111 and `tx_link` driven equal to `tx_ser`, `tx_out` reproduces `tx_ser` one clock late at every position.
- R10: A pulse on `rx_sync` or `tx_sync` makes that clock phase 0 of bit 0 of an even frame, overriding the running count.
- R11: While `rst_n` is low all outputs are 0; after release, counting starts at phase 0 of bit 0 of an even frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one E1 bit lasts BIT_PHASES cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sync | input | 1 | Receive restart strobe for phase 0, bit 0, even frame |
| rx_ser | input | 1 | Received serial data, held for a whole bit |
| rx_sa_mask | input | 5 | Spare-bit slots that gate the receive link clock (bit 0 = Sa4) |
| rx_link | output | 1 | All received data, delayed one clock |
| rx_lclk | output | 1 | Gated, centred link clock over the selected spare bits |
| rx_fsync | output | 1 | High during the Si slot of each frame |
| tx_sync | input | 1 | Transmit restart strobe for phase 0, bit 0, even frame |
| tx_ser | input | 1 | Transmit serial data |
| tx_link | input | 1 | External spare-bit source |
| tx_sa_mask | input | 5 | Per spare bit: 1 = take tx_link, 0 = take tx_sa_reg |
| tx_sa_reg | input | 5 | Host spare-bit value, latched at frame start |
| tx_out | output | 1 | Outgoing stream with the spare bits filled in |

## Verification
Two things can land on the same clock. One is the sync strobe restarting the position counter. The other is the free-running count that would otherwise carry on. The bench pulses sync again 100 bits into a frame and checks that `rx_fsync` and the spare-bit clock follow the new origin from the next clock. It also changes the host spare-bit value in the middle of an odd frame. That value must not appear before the next frame-start capture, and it must appear in full one frame pair later.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
   localparam int FRAME_BITS = 256;
   localparam int SI_BIT     = 0;
   localparam int SA_FIRST   = 3;
   localparam int SA_NUM     = 5;

   typedef logic [$clog2(FRAME_BITS)-1:0] bit_idx_t;
   typedef logic [SA_NUM-1:0]             sa_vec_t;

   // one-hot flag of the spare-bit slot at frame bit b (zero outside odd frames)
   function automatic sa_vec_t sa_onehot(input bit_idx_t b, input logic odd);
      sa_vec_t v;
      v = '0;
      for (int k = 0; k < SA_NUM; k++)
         if (odd && b == bit_idx_t'(SA_FIRST + k)) v[k] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/e1_sa_timer.sv
module e1_sa_timer
   import e1_sa_pkg::*;
#(
   parameter int BIT_PHASES = 4,
   localparam int PH_W = $clog2(BIT_PHASES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sync,
   output logic [PH_W-1:0] ph,
   output bit_idx_t        bidx,
   output logic            odd
);
   localparam logic [PH_W-1:0] PH_LAST  = PH_W'(BIT_PHASES - 1);
   localparam bit_idx_t        BIT_LAST = bit_idx_t'(FRAME_BITS - 1);

   logic [PH_W-1:0] ph_q;
   bit_idx_t        bit_q;
   logic            odd_q;

   // a sync strobe names the current clock as the frame origin
   always_comb begin
      ph   = sync ? '0   : ph_q;
      bidx = sync ? '0   : bit_q;
      odd  = sync ? 1'b0 : odd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         bit_q <= '0;
         odd_q <= 1'b0;
      end else if (ph == PH_LAST) begin
         ph_q  <= '0;
         bit_q <= (bidx == BIT_LAST) ? '0 : bidx + 1'b1;
         odd_q <= (bidx == BIT_LAST) ? ~odd : odd;
      end else begin
         ph_q  <= ph + 1'b1;
         bit_q <= bidx;
         odd_q <= odd;
      end
   end
endmodule

// File: rtl/e1_sa_rx.sv
module e1_sa_rx
   import e1_sa_pkg::*;
#(
   parameter int BIT_PHASES = 4,
   localparam int PH_W = $clog2(BIT_PHASES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PH_W-1:0] ph,
   input  bit_idx_t        bidx,
   input  logic            odd,
   input  logic            ser,
   input  sa_vec_t         mask,
   output logic            link,
   output logic            lclk,
   output logic            fsync
);
   localparam int WIN_LO = BIT_PHASES / 4;
   localparam int WIN_HI = WIN_LO + BIT_PHASES / 2;

   sa_vec_t slot, gate;
   logic    centre;

   assign slot   = sa_onehot(bidx, odd);
   assign centre = (ph >= PH_W'(WIN_LO)) && (ph < PH_W'(WIN_HI));

   for (genvar k = 0; k < SA_NUM; k++) begin : g_gate
      assign gate[k] = slot[k] & mask[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link  <= 1'b0;
         lclk  <= 1'b0;
         fsync <= 1'b0;
      end else begin
         link  <= ser;
         lclk  <= (|gate) & centre;
         fsync <= (bidx == bit_idx_t'(SI_BIT));
      end
   end
endmodule

// File: rtl/e1_sa_tx.sv
module e1_sa_tx
   import e1_sa_pkg::*;
#(
   parameter int BIT_PHASES = 4,
   localparam int PH_W = $clog2(BIT_PHASES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PH_W-1:0] ph,
   input  bit_idx_t        bidx,
   input  logic            odd,
   input  logic            ser,
   input  logic            link,
   input  sa_vec_t         mask,
   input  sa_vec_t         sa_reg,
   output logic            dout,
   output sa_vec_t         hold
);
   sa_vec_t slot, pick;
   logic    frame_start, sa_hit, sa_val;

   assign slot        = sa_onehot(bidx, odd);
   assign frame_start = (ph == '0) && (bidx == '0);

   for (genvar k = 0; k < SA_NUM; k++) begin : g_pick
      assign pick[k] = mask[k] ? link : hold[k];
   end

   assign sa_hit = |slot;
   assign sa_val = |(slot & pick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= '0;
         dout <= 1'b0;
      end else begin
         if (frame_start) hold <= sa_reg;
         dout <= sa_hit ? sa_val : ser;
      end
   end
endmodule

// File: rtl/e1_sa_link.sv
module e1_sa_link
   import e1_sa_pkg::*;
#(
   parameter int BIT_PHASES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_sync,
   input  logic       rx_ser,
   input  logic [4:0] rx_sa_mask,
   output logic       rx_link,
   output logic       rx_lclk,
   output logic       rx_fsync,
   input  logic       tx_sync,
   input  logic       tx_ser,
   input  logic       tx_link,
   input  logic [4:0] tx_sa_mask,
   input  logic [4:0] tx_sa_reg,
   output logic       tx_out
);
   localparam int PH_W = $clog2(BIT_PHASES);

   if (BIT_PHASES < 4 || (BIT_PHASES % 2) != 0) begin : g_bad_phases
      $error("BIT_PHASES must be even and at least 4");
   end
   if (SA_NUM != 5) begin : g_bad_sa
      $error("mask ports assume five spare bits");
   end

   logic [PH_W-1:0] rx_ph, tx_ph;
   bit_idx_t        rx_bit, tx_bit;
   logic            rx_odd, tx_odd;
   sa_vec_t         tx_hold;

   e1_sa_timer #(.BIT_PHASES(BIT_PHASES)) u_rx_tmr (
      .clk(clk), .rst_n(rst_n), .sync(rx_sync),
      .ph(rx_ph), .bidx(rx_bit), .odd(rx_odd));

   e1_sa_timer #(.BIT_PHASES(BIT_PHASES)) u_tx_tmr (
      .clk(clk), .rst_n(rst_n), .sync(tx_sync),
      .ph(tx_ph), .bidx(tx_bit), .odd(tx_odd));

   e1_sa_rx #(.BIT_PHASES(BIT_PHASES)) u_rx (
      .clk(clk), .rst_n(rst_n), .ph(rx_ph), .bidx(rx_bit), .odd(rx_odd),
      .ser(rx_ser), .mask(rx_sa_mask),
      .link(rx_link), .lclk(rx_lclk), .fsync(rx_fsync));

   e1_sa_tx #(.BIT_PHASES(BIT_PHASES)) u_tx (
      .clk(clk), .rst_n(rst_n), .ph(tx_ph), .bidx(tx_bit), .odd(tx_odd),
      .ser(tx_ser), .link(tx_link), .mask(tx_sa_mask), .sa_reg(tx_sa_reg),
      .dout(tx_out), .hold(tx_hold));
endmodule

// File: rtl/e1_sa_link_chk.sv
module e1_sa_link_chk
   import e1_sa_pkg::*;
#(
   parameter int BIT_PHASES = 4,
   localparam int PH_W = $clog2(BIT_PHASES)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rx_ser,
   input logic [4:0]      rx_sa_mask,
   input logic            rx_link,
   input logic            rx_lclk,
   input logic            rx_fsync,
   input logic            tx_sync,
   input logic            tx_ser,
   input logic            tx_out,
   input logic [PH_W-1:0] rx_ph,
   input bit_idx_t        rx_bit,
   input logic            rx_odd,
   input logic [PH_W-1:0] tx_ph,
   input bit_idx_t        tx_bit,
   input logic            tx_odd,
   input sa_vec_t         tx_hold
);
   localparam int WIN_LO = BIT_PHASES / 4;
   localparam int WIN_HI = WIN_LO + BIT_PHASES / 2;

   logic mask_here;
   always_comb begin
      mask_here = 1'b0;
      for (int k = 0; k < SA_NUM; k++)
         if (rx_bit == bit_idx_t'(SA_FIRST + k)) mask_here = rx_sa_mask[k];
   end

   AST_LINK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> rx_link == $past(rx_ser)); // R1
   AST_FSYNC_AT_SI: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fsync |-> $past(rx_bit) == bit_idx_t'(SI_BIT)); // R2
   AST_LCLK_IN_SA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_lclk |-> $past(rx_odd) && $past(mask_here)); // R3
   AST_LCLK_CENTRED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_lclk |-> ($past(rx_ph) >= PH_W'(WIN_LO)) && ($past(rx_ph) < PH_W'(WIN_HI))); // R4
   AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bit >= bit_idx_t'(8)) |=> tx_out == $past(tx_ser)); // R5
   AST_SA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_ph == '0 && tx_bit == '0) |=> $stable(tx_hold)); // R8
   AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sync |=> (tx_bit == '0) && (tx_ph == PH_W'(1)) && !tx_odd); // R10
endmodule

bind e1_sa_link e1_sa_link_chk #(.BIT_PHASES(BIT_PHASES)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_ser(rx_ser), .rx_sa_mask(rx_sa_mask),
   .rx_link(rx_link), .rx_lclk(rx_lclk), .rx_fsync(rx_fsync),
   .tx_sync(tx_sync), .tx_ser(tx_ser), .tx_out(tx_out),
   .rx_ph(rx_ph), .rx_bit(rx_bit), .rx_odd(rx_odd),
   .tx_ph(tx_ph), .tx_bit(tx_bit), .tx_odd(tx_odd), .tx_hold(tx_hold));

// File: tb/e1_sa_link_tb.sv
module e1_sa_link_tb;
   localparam int P  = 4;
   localparam int FB = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_sync = 1'b0, rx_ser = 1'b0;
   logic [4:0] rx_sa_mask = '0;
   logic rx_link, rx_lclk, rx_fsync;
   logic tx_sync = 1'b0, tx_ser = 1'b0, tx_link = 1'b0;
   logic [4:0] tx_sa_mask = '0, tx_sa_reg = '0;
   logic tx_out;

   always #4 clk = ~clk;

   e1_sa_link #(.BIT_PHASES(P)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_sync(rx_sync), .rx_ser(rx_ser),
      .rx_sa_mask(rx_sa_mask), .rx_link(rx_link), .rx_lclk(rx_lclk),
      .rx_fsync(rx_fsync), .tx_sync(tx_sync), .tx_ser(tx_ser),
      .tx_link(tx_link), .tx_sa_mask(tx_sa_mask), .tx_sa_reg(tx_sa_reg),
      .tx_out(tx_out));

   int n_chk = 0, n_fail = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic exp_valid = 1'b0;
   logic exp_link, exp_lclk, exp_fsync, exp_tx;
   string tg_link, tg_lclk, tg_fsync, tg_tx;
   logic [4:0] sa_frame = '0;

   // {rx_mask, tx_mask, sa_start, sa_mid, tie_link_to_ser}
   localparam logic [20:0] VEC [6] = '{
      {5'b11111, 5'b00000, 5'b10101, 5'b01010, 1'b0},
      {5'b00000, 5'b11111, 5'b11111, 5'b00000, 1'b1},
      {5'b10001, 5'b01010, 5'b00110, 5'b11001, 1'b0},
      {5'b01110, 5'b10100, 5'b11000, 5'b00111, 1'b0},
      {5'b00100, 5'b11111, 5'b00000, 5'b11111, 1'b0},
      {5'b11011, 5'b00001, 5'b01111, 5'b10000, 1'b1}
   };

   task automatic chk(input string tag, input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%b exp=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_prev();
      if (exp_valid) begin
         chk(tg_link,  rx_link,  exp_link,  "rx_link");
         chk(tg_fsync, rx_fsync, exp_fsync, "rx_fsync");
         chk(tg_lclk,  rx_lclk,  exp_lclk,  "rx_lclk");
         chk(tg_tx,    tx_out,   exp_tx,    "tx_out");
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic run(input int nbits, input logic do_sync, input logic release_rst,
                      input logic [4:0] rxm, input logic [4:0] txm,
                      input logic [4:0] sa0, input logic [4:0] mid,
                      input logic tie, input string fs_tag);
      for (int n = 0; n < nbits; n++) begin
         for (int p = 0; p < P; p++) begin
            int  bi;
            logic odd, is_sa;
            int  k;
            bi  = n % FB;
            odd = ((n / FB) % 2) == 1;
            @(negedge clk);
            check_prev();
            if (n == 0 && p == 0) begin
               rx_sa_mask = rxm;
               tx_sa_mask = txm;
               tx_sa_reg  = sa0;
               if (release_rst) rst_n = 1'b1;
            end
            if (n == FB + 5 && p == 0) tx_sa_reg = mid;   // R8: change mid-frame
            rx_sync = do_sync && n == 0 && p == 0;
            tx_sync = do_sync && n == 0 && p == 0;
            if (p == 0) begin
               rx_ser  = lfsr[0];
               tx_ser  = lfsr[5];
               tx_link = tie ? lfsr[5] : lfsr[11];
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            end
            if (bi == 0 && p == 0) sa_frame = tx_sa_reg;
            is_sa = odd && bi >= 3 && bi <= 7;
            k = is_sa ? bi - 3 : 0;
            exp_link  = rx_ser;
            exp_fsync = (bi == 0);
            exp_lclk  = is_sa && rxm[k] && p >= P / 4 && p < P / 4 + P / 2;
            exp_tx    = is_sa ? (txm[k] ? tx_link : sa_frame[k]) : tx_ser;
            tg_link   = (fs_tag == "R2") ? "R1" : fs_tag;
            tg_fsync  = fs_tag;
            tg_lclk   = (is_sa && rxm[k]) ? "R4" : "R3";
            tg_tx     = tie ? "R9" : !is_sa ? "R5" : txm[k] ? "R6" : (n >= 2 * FB) ? "R8" : "R7";
            exp_valid = 1'b1;
         end
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", rx_link,  1'b0, "rx_link in reset");
      chk("R11", rx_lclk,  1'b0, "rx_lclk in reset");
      chk("R11", rx_fsync, 1'b0, "rx_fsync in reset");
      chk("R11", tx_out,   1'b0, "tx_out in reset");
      // table walk: four frames per row, started by a sync pulse
      run(1, 1'b0, 1'b1, 5'b0, 5'b0, 5'b0, 5'b0, 1'b0, "R11");
      for (int v = 0; v < 6; v++)
         run(4 * FB, 1'b1, 1'b0, VEC[v][20:16], VEC[v][15:11], VEC[v][10:6],
             VEC[v][5:1], VEC[v][0], "R2");
      // R10: resync 100 bits into a frame
      run(100, 1'b1, 1'b0, 5'b11111, 5'b01010, 5'b10011, 5'b01100, 1'b0, "R2");
      run(2 * FB + 20, 1'b1, 1'b0, 5'b11111, 5'b01010, 5'b10011, 5'b01100, 1'b0, "R10");
      // R11: reset in mid-stream, then free-run from release with no sync
      @(negedge clk);
      check_prev();
      exp_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11", rx_link,  1'b0, "rx_link in reset");
      chk("R11", rx_lclk,  1'b0, "rx_lclk in reset");
      chk("R11", rx_fsync, 1'b0, "rx_fsync in reset");
      chk("R11", tx_out,   1'b0, "tx_out in reset");
      run(2 * FB, 1'b0, 1'b1, 5'b10101, 5'b00110, 5'b11100, 5'b11100, 1'b0, "R11");
      @(negedge clk);
      check_prev();
      finish_up();
   end
endmodule